// File: doc/BRIEF.md
# Sampling Phase Sweep Controller

This block runs the receive-timing tuning pass of a high-speed memory-card host. Once started, it walks the receive sampling phase upward from 0. For each phase it first asks an external delay-line sequencer to apply that phase. It then issues a tuning-block read through a request/acknowledge command port. While the read runs, the returned bytes are checked against a pattern that the block generates itself. A phase counts as passing only when the read finished cleanly and the data is exact.

A read that reports an error sends the controller into a bounded status-poll loop, and that phase is recorded as failed. A sweep in which every phase passes means the window cannot be seen. In that case the controller raises the card drive type one step at a time and sweeps again. Afterwards it restores the default drive type. If the window is still fully open, it raises a warning and issues one more tuning read with clock-data recovery enabled. The final 16-bit pass mask goes to a separate phase-selection block, along with a done pulse and an error flag.

Top module: `tune_sweep_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, err_o, warn_o, pass_mask_o and all three request outputs are low.
- R2: start_i while idle raises busy_o in the next cycle. busy_o then stays high until the done pulse. A start_i seen while busy_o is high is ignored, so each run gives exactly one done pulse.
- R3: Phase requests are issued in ascending order from 0 to 15. A sweep restart begins again at 0. ph_val_o holds steady while a request waits for its acknowledge.
- R4: Expected byte i equals (29*i + B) mod 256, where B = 0x4B for the 4-bit bus (bus_wide_i=0, 64 bytes) and B = 0xA7 for the 8-bit bus (bus_wide_i=1, 128 bytes). A phase passes only if the read is acknowledged without error, exactly the pattern length of bytes arrived, and every byte matched. Bit n of pass_mask_o reports phase n.
- R5: A tuning read acknowledged with cmd_err_i starts status polls (cmd_kind_o=1). Polling stops at the first error-free acknowledge with card_tran_i high, or after 100 polls. Consecutive polls are at least POLL_GAP cycles apart. That phase is failed.
- R6: If all 16 phases pass, the drive type is raised by one, up to 3, through the drive port. An accepted value (drv_ok_i=1) restarts the sweep with a cleared mask. A rejected value is followed at once by the next one.
- R7: If any drive change was accepted, a drive request with value 0 is issued before the run ends.
- R8: If the final mask is all ones, warn_o is set and one extra tuning read with cdr_en_o high is issued before done. warn_o clears on the next start.
- R9: A run ending with no passing phase reports err_o=1 with its done pulse. Otherwise err_o=0.
- R10: A phase request acknowledged with ph_err_i ends the run at once with err_o=1. The mask keeps the phases that passed before the abort.
- R11: done_o is a single-cycle pulse that appears in the first cycle busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a tuning run |
| bus_wide_i | input | 1 | 1 = 8-bit bus (128-byte pattern), 0 = 4-bit bus (64-byte pattern) |
| ph_req_o | output | 1 | Request to apply a sampling phase |
| ph_val_o | output | 4 | Phase to apply |
| ph_ack_i | input | 1 | Phase request completed |
| ph_err_i | input | 1 | Phase programming failed, valid with ph_ack_i |
| cmd_req_o | output | 1 | Command request |
| cmd_kind_o | output | 1 | 0 = tuning read, 1 = status poll |
| cdr_en_o | output | 1 | Clock-data recovery enabled for the current read |
| cmd_ack_i | input | 1 | Command completed |
| cmd_err_i | input | 1 | Command error, valid with cmd_ack_i |
| card_tran_i | input | 1 | Card in transfer state, valid with a status acknowledge |
| rx_valid_i | input | 1 | Received byte valid |
| rx_byte_i | input | 8 | Received byte |
| drv_req_o | output | 1 | Drive type change request |
| drv_val_o | output | 2 | Requested drive type |
| drv_ack_i | input | 1 | Drive request completed |
| drv_ok_i | input | 1 | Drive change accepted, valid with drv_ack_i |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | End-of-run pulse |
| err_o | output | 1 | Run failed |
| warn_o | output | 1 | Every phase passed after escalation |
| pass_mask_o | output | 16 | Per-phase pass result |

## Verification
Some properties are checked on every cycle. These cover the done pulse shape and how it lines up with the fall of busy, the stability of the phase value under a pending request, the coupling of the recovery-enabled read to the warning, the poll ceiling per phase, and the error flag on an empty mask. Other behaviour can only be shown by the bench scenarios, which need a modelled card to provide it. That includes the exact data comparison and its length rule, early poll exit on the transfer state, the order of drive escalation with rejected values skipped, the drive restore, the abort on a programming failure, and the rejection of a second start.

// File: rtl/tune_pkg.sv
package tune_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PH, ST_RD, ST_POLL, ST_GAP, ST_NEXT, ST_DRV, ST_RST, ST_CDR
  } tune_st_e;

  localparam logic CMD_TUNE = 1'b0;
  localparam logic CMD_STAT = 1'b1;

  localparam logic [7:0] PAT_STEP        = 8'd29;
  localparam logic [7:0] PAT_BASE_NARROW = 8'h4B;
  localparam logic [7:0] PAT_BASE_WIDE   = 8'hA7;
endpackage

// File: rtl/tune_pat_rom.sv
module tune_pat_rom
  import tune_pkg::*;
#(
  parameter int IDXW = 8
) (
  input  logic [IDXW-1:0] idx_i,
  input  logic            wide_i,
  output logic [7:0]      byte_o
);
  logic [7:0] base;
  logic [7:0] idx8;

  generate
    if (IDXW >= 8) begin : g_trunc
      assign idx8 = idx_i[7:0];
    end else begin : g_pad
      assign idx8 = {{(8-IDXW){1'b0}}, idx_i};
    end
  endgenerate

  assign base   = wide_i ? PAT_BASE_WIDE : PAT_BASE_NARROW;
  assign byte_o = 8'(idx8 * PAT_STEP) + base;
endmodule

// File: rtl/tune_rx_chk.sv
module tune_rx_chk #(
  parameter int LEN_NARROW = 64,
  parameter int LEN_WIDE   = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       wide_i,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  output logic       ok_o
);
  localparam int CNTW = $clog2(LEN_WIDE + 1);

  logic [CNTW-1:0] cnt_q;
  logic            bad_q;
  logic [CNTW-1:0] len;
  logic [7:0]      exp_byte;

  assign len = wide_i ? CNTW'(LEN_WIDE) : CNTW'(LEN_NARROW);

  tune_pat_rom #(.IDXW(CNTW)) u_rom (
    .idx_i  (cnt_q),
    .wide_i (wide_i),
    .byte_o (exp_byte)
  );

  // counter and error latch are held clear outside a read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else if (!arm_i) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else if (vld_i) begin
      if (cnt_q == len) begin
        bad_q <= 1'b1;
      end else begin
        if (byte_i != exp_byte) bad_q <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ok_o = !bad_q && (cnt_q == len);
endmodule

// File: rtl/tune_poll_tmr.sv
module tune_poll_tmr #(
  parameter int LIMIT = 100,
  parameter int GAP   = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hit_i,
  input  logic gap_run_i,
  output logic last_o,
  output logic gap_done_o
);
  localparam int PCW = $clog2(LIMIT + 1);
  localparam int GCW = $clog2(GAP + 1);

  logic [PCW-1:0] poll_q;
  logic [GCW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q <= '0;
    end else if (clr_i) begin
      poll_q <= '0;
    end else if (hit_i) begin
      poll_q <= poll_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
    end else if (!gap_run_i || gap_done_o) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assign last_o     = (poll_q == PCW'(LIMIT - 1));
  assign gap_done_o = (gap_q == GCW'(GAP - 1));
endmodule

// File: rtl/tune_sweep_ctrl.sv
module tune_sweep_ctrl
  import tune_pkg::*;
#(
  parameter int PHASES     = 16,
  parameter int DRV_MAX    = 3,
  parameter int LEN_NARROW = 64,
  parameter int LEN_WIDE   = 128,
  parameter int POLL_LIMIT = 100,
  parameter int POLL_GAP   = 500,
  localparam int PW = $clog2(PHASES),
  localparam int DW = $clog2(DRV_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bus_wide_i,
  output logic              ph_req_o,
  output logic [PW-1:0]     ph_val_o,
  input  logic              ph_ack_i,
  input  logic              ph_err_i,
  output logic              cmd_req_o,
  output logic              cmd_kind_o,
  output logic              cdr_en_o,
  input  logic              cmd_ack_i,
  input  logic              cmd_err_i,
  input  logic              card_tran_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic              drv_req_o,
  output logic [DW-1:0]     drv_val_o,
  input  logic              drv_ack_i,
  input  logic              drv_ok_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              warn_o,
  output logic [PHASES-1:0] pass_mask_o
);
  localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);
  localparam logic [DW-1:0] TOP_DRV = DW'(DRV_MAX);

  tune_st_e          st_q;
  logic [PW-1:0]     phase_q;
  logic [PHASES-1:0] mask_q;
  logic [DW-1:0]     drv_q;
  logic              chg_q, warn_q, err_q, done_q, wide_q;
  logic              rx_arm, rx_ok, poll_last, gap_done, all_pass;

  assign all_pass = &mask_q;
  assign rx_arm   = (st_q == ST_RD) || (st_q == ST_CDR);

  tune_rx_chk #(.LEN_NARROW(LEN_NARROW), .LEN_WIDE(LEN_WIDE)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (rx_arm),
    .wide_i (wide_q),
    .vld_i  (rx_valid_i),
    .byte_i (rx_byte_i),
    .ok_o   (rx_ok)
  );

  tune_poll_tmr #(.LIMIT(POLL_LIMIT), .GAP(POLL_GAP)) u_poll (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (st_q == ST_RD),
    .hit_i      ((st_q == ST_POLL) && cmd_ack_i),
    .gap_run_i  (st_q == ST_GAP),
    .last_o     (poll_last),
    .gap_done_o (gap_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      phase_q <= '0;
      mask_q  <= '0;
      drv_q   <= '0;
      chg_q   <= 1'b0;
      warn_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_PH;
          phase_q <= '0;
          mask_q  <= '0;
          drv_q   <= '0;
          chg_q   <= 1'b0;
          warn_q  <= 1'b0;
          err_q   <= 1'b0;
          wide_q  <= bus_wide_i;
        end
        ST_PH: if (ph_ack_i) begin
          if (ph_err_i) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_RD;
          end
        end
        ST_RD: if (cmd_ack_i) begin
          if (cmd_err_i) begin
            st_q <= ST_POLL;
          end else begin
            mask_q[phase_q] <= rx_ok;
            st_q            <= ST_NEXT;
          end
        end
        ST_POLL: if (cmd_ack_i) begin
          st_q <= ((!cmd_err_i && card_tran_i) || poll_last) ? ST_NEXT : ST_GAP;
        end
        ST_GAP: if (gap_done) st_q <= ST_POLL;
        ST_NEXT: begin
          if (phase_q != LAST_PH) begin
            phase_q <= phase_q + 1'b1;
            st_q    <= ST_PH;
          end else if (all_pass && (drv_q < TOP_DRV)) begin
            drv_q <= drv_q + 1'b1;
            st_q  <= ST_DRV;
          end else if (chg_q) begin
            st_q <= ST_RST;
          end else if (all_pass) begin
            warn_q <= 1'b1;
            st_q   <= ST_CDR;
          end else begin
            done_q <= 1'b1;
            err_q  <= (mask_q == '0);
            st_q   <= ST_IDLE;
          end
        end
        ST_DRV: if (drv_ack_i) begin
          if (drv_ok_i) begin
            chg_q   <= 1'b1;
            phase_q <= '0;
            mask_q  <= '0;
            st_q    <= ST_PH;
          end else if (drv_q < TOP_DRV) begin
            drv_q <= drv_q + 1'b1;
          end else if (chg_q) begin
            st_q <= ST_RST;
          end else begin
            warn_q <= 1'b1;
            st_q   <= ST_CDR;
          end
        end
        ST_RST: if (drv_ack_i) begin
          if (all_pass) begin
            warn_q <= 1'b1;
            st_q   <= ST_CDR;
          end else begin
            done_q <= 1'b1;
            err_q  <= (mask_q == '0);
            st_q   <= ST_IDLE;
          end
        end
        ST_CDR: if (cmd_ack_i) begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ph_req_o    = (st_q == ST_PH);
  assign ph_val_o    = phase_q;
  assign cmd_req_o   = (st_q == ST_RD) || (st_q == ST_POLL) || (st_q == ST_CDR);
  assign cmd_kind_o  = (st_q == ST_POLL) ? CMD_STAT : CMD_TUNE;
  assign cdr_en_o    = (st_q == ST_CDR);
  assign drv_req_o   = (st_q == ST_DRV) || (st_q == ST_RST);
  assign drv_val_o   = (st_q == ST_RST) ? '0 : drv_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign warn_o      = warn_q;
  assign pass_mask_o = mask_q;
endmodule

// File: rtl/tune_sweep_chk.sv
module tune_sweep_chk #(
  parameter int PHASES     = 16,
  parameter int PW         = 4,
  parameter int POLL_LIMIT = 100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              warn_o,
  input logic [PHASES-1:0] pass_mask_o,
  input logic              ph_req_o,
  input logic              ph_ack_i,
  input logic [PW-1:0]     ph_val_o,
  input logic              cmd_req_o,
  input logic              cmd_kind_o,
  input logic              cmd_ack_i,
  input logic              cdr_en_o
);
  logic [15:0] polls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) polls_q <= '0;
    else if (ph_req_o) polls_q <= '0;
    else if (cmd_req_o && cmd_kind_o && cmd_ack_i) polls_q <= polls_q + 1'b1;
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R2
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R9
  empty_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (pass_mask_o == '0)) |-> err_o);
  // R3
  ph_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_req_o && !ph_ack_i) |=> (ph_req_o && $stable(ph_val_o)));
  // R8
  cdr_warn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdr_en_o |-> (warn_o && cmd_req_o && !cmd_kind_o));
  // R5
  poll_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    polls_q <= 16'(POLL_LIMIT));
endmodule

bind tune_sweep_ctrl tune_sweep_chk #(
  .PHASES(PHASES), .PW(PW), .POLL_LIMIT(POLL_LIMIT)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .warn_o(warn_o), .pass_mask_o(pass_mask_o),
  .ph_req_o(ph_req_o), .ph_ack_i(ph_ack_i), .ph_val_o(ph_val_o),
  .cmd_req_o(cmd_req_o), .cmd_kind_o(cmd_kind_o), .cmd_ack_i(cmd_ack_i),
  .cdr_en_o(cdr_en_o)
);

// File: tb/tune_sweep_ctrl_tb_top.sv
module tune_sweep_ctrl_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, bus_wide_i = 1'b0;
  logic ph_req_o; logic [3:0] ph_val_o;
  logic ph_ack_i = 1'b0, ph_err_i = 1'b0;
  logic cmd_req_o, cmd_kind_o, cdr_en_o;
  logic cmd_ack_i = 1'b0, cmd_err_i = 1'b0, card_tran_i = 1'b0;
  logic rx_valid_i = 1'b0; logic [7:0] rx_byte_i = 8'h00;
  logic drv_req_o; logic [1:0] drv_val_o;
  logic drv_ack_i = 1'b0, drv_ok_i = 1'b0;
  logic busy_o, done_o, err_o, warn_o;
  logic [15:0] pass_mask_o;

  always #10 clk_i = ~clk_i;

  tune_sweep_ctrl #(.POLL_GAP(4)) dut_i (.*);

  typedef struct {
    logic [15:0] mask;
    logic        err;
    logic        warn;
    logic [15:0] dlog;
    int          polls;
    int          cdr;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, n_done = 0;

  // card model configuration
  logic [15:0] pass_tab [4];
  logic [3:0]  accept;
  int          fail_kind [16];  // 0 mismatch, 1 short, 2 command error
  int          tran_at;
  int          abort_ph;
  // card model observations
  logic [1:0]  cur_drv;
  logic [15:0] dlog;
  int polls, cdr_n, order_err, last_ph, poll_n;

  function automatic logic [7:0] pat(input int i, input logic wide);
    return 8'(29 * i + (wide ? 8'hA7 : 8'h4B));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic send_read(input logic good, input int kind, input int p);
    int n;
    n = bus_wide_i ? 128 : 64;
    if (!good && kind == 1) n = n - 1;
    if (good || kind != 2) begin
      for (int i = 0; i < n; i++) begin
        rx_valid_i = 1'b1;
        rx_byte_i  = pat(i, bus_wide_i) ^ ((!good && kind == 0 && i == 7) ? 8'h10 : 8'h00);
        @(negedge clk_i);
      end
    end
    rx_valid_i = 1'b0;
    cmd_ack_i  = 1'b1;
    cmd_err_i  = (!good && kind == 2 && p >= 0);
    @(negedge clk_i);
    cmd_ack_i = 1'b0;
    cmd_err_i = 1'b0;
  endtask

  // card, delay-line sequencer and drive-control model
  initial begin
    int p;
    forever begin
      @(negedge clk_i);
      if (ph_req_o) begin
        p = int'(ph_val_o);
        if (p != 0 && p != last_ph + 1) order_err++;
        last_ph = p;
        poll_n  = 0;
        @(negedge clk_i);
        ph_ack_i = 1'b1;
        ph_err_i = (p == abort_ph);
        @(negedge clk_i);
        ph_ack_i = 1'b0;
        ph_err_i = 1'b0;
      end else if (drv_req_o) begin
        logic [1:0] v;
        v    = drv_val_o;
        dlog = (dlog << 4) | {12'h0, 2'b10, v};
        @(negedge clk_i);
        drv_ack_i = 1'b1;
        drv_ok_i  = (v == 2'd0) || accept[v];
        if (drv_ok_i) cur_drv = v;
        @(negedge clk_i);
        drv_ack_i = 1'b0;
        drv_ok_i  = 1'b0;
      end else if (cmd_req_o && !cmd_kind_o) begin
        if (cdr_en_o) begin
          cdr_n++;
          send_read(1'b1, 0, 0);
        end else begin
          send_read(pass_tab[cur_drv][last_ph], fail_kind[last_ph], last_ph);
        end
      end else if (cmd_req_o && cmd_kind_o) begin
        poll_n++;
        polls++;
        @(negedge clk_i);
        cmd_ack_i   = 1'b1;
        card_tran_i = (tran_at != 0 && poll_n == tran_at);
        @(negedge clk_i);
        cmd_ack_i   = 1'b0;
        card_tran_i = 1'b0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i);
      if (done_o) begin
        n_done++;
        if (exp_q.size() == 0) begin
          check("R2 unexpected done", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          check("R4 pass mask", 32'(pass_mask_o), 32'(e.mask));
          check("R9 R10 err", 32'(err_o), 32'(e.err));
          check("R8 warn", 32'(warn_o), 32'(e.warn));
          check("R6 R7 drive log", 32'(dlog), 32'(e.dlog));
          check("R5 poll count", 32'(polls), 32'(e.polls));
          check("R8 cdr reads", 32'(cdr_n), 32'(e.cdr));
          check("R3 phase order", 32'(order_err), 32'd0);
          check("R11 busy low at done", 32'(busy_o), 32'd0);
        end
        @(negedge clk_i);
        check("R11 done one cycle", 32'(done_o), 32'd0);
      end
    end
  end

  task automatic run_case(input logic wide, input logic [15:0] t0, input logic [15:0] t1,
                          input logic [15:0] t2, input logic [15:0] t3, input logic [3:0] acc,
                          input int tr, input int ab, input exp_t e, input logic restart);
    int d0;
    bus_wide_i = wide;
    pass_tab[0] = t0; pass_tab[1] = t1; pass_tab[2] = t2; pass_tab[3] = t3;
    accept = acc; tran_at = tr; abort_ph = ab;
    cur_drv = 2'd0; dlog = 16'h0; polls = 0; cdr_n = 0; order_err = 0; last_ph = -1;
    exp_q.push_back(e);
    d0 = n_done;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R2 busy after start", 32'(busy_o), 32'd1);
    if (restart) begin
      repeat (300) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait (n_done > d0);
    repeat (20) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R2 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    exp_t e;
    for (int i = 0; i < 16; i++) fail_kind[i] = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 busy", 32'(busy_o), 32'd0);
    check("R1 done", 32'(done_o), 32'd0);
    check("R1 err", 32'(err_o), 32'd0);
    check("R1 warn", 32'(warn_o), 32'd0);
    check("R1 mask", 32'(pass_mask_o), 32'd0);
    check("R1 requests", 32'({ph_req_o, cmd_req_o, drv_req_o}), 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R4 narrow bus, contiguous window, mismatching bytes elsewhere
    e = '{mask:16'h0FF0, err:1'b0, warn:1'b0, dlog:16'h0, polls:0, cdr:0};
    run_case(1'b0, 16'h0FF0, 16'h0, 16'h0, 16'h0, 4'h0, 0, 99, e, 1'b0);

    // R4 R5 wide bus, short read on phase 6, command error on phase 3 left after 3 polls
    fail_kind[3] = 2; fail_kind[6] = 1;
    e = '{mask:16'h8001, err:1'b0, warn:1'b0, dlog:16'h0, polls:3, cdr:0};
    run_case(1'b1, 16'h8001, 16'h0, 16'h0, 16'h0, 4'h0, 3, 99, e, 1'b0);
    fail_kind[3] = 0; fail_kind[6] = 0;

    // R5 R9 nothing passes, phase 0 never reaches transfer state: 100 polls
    fail_kind[0] = 2;
    e = '{mask:16'h0000, err:1'b1, warn:1'b0, dlog:16'h0, polls:100, cdr:0};
    run_case(1'b0, 16'h0, 16'h0, 16'h0, 16'h0, 4'h0, 0, 99, e, 1'b0);
    fail_kind[0] = 0;

    // R6 R7 escalation to drive 1 narrows window, then restore to 0
    e = '{mask:16'h00FF, err:1'b0, warn:1'b0, dlog:16'h0098, polls:0, cdr:0};
    run_case(1'b0, 16'hFFFF, 16'h00FF, 16'h0, 16'h0, 4'b0010, 0, 99, e, 1'b0);

    // R6 R7 R8 drive 1 rejected, 2 and 3 accepted, window stays open
    e = '{mask:16'hFFFF, err:1'b0, warn:1'b1, dlog:16'h9AB8, polls:0, cdr:1};
    run_case(1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'b1100, 0, 99, e, 1'b0);

    // R6 R8 all drive values rejected: no restore, warning and recovery read
    e = '{mask:16'hFFFF, err:1'b0, warn:1'b1, dlog:16'h09AB, polls:0, cdr:1};
    run_case(1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'b0000, 0, 99, e, 1'b0);

    // R10 programming failure at phase 5; R8 warning cleared by this start
    e = '{mask:16'h001F, err:1'b1, warn:1'b0, dlog:16'h0, polls:0, cdr:0};
    run_case(1'b0, 16'h0FFF, 16'h0, 16'h0, 16'h0, 4'h0, 0, 5, e, 1'b0);

    // R2 start while busy ignored: exactly one done
    e = '{mask:16'h3C00, err:1'b0, warn:1'b0, dlog:16'h0, polls:0, cdr:0};
    run_case(1'b0, 16'h3C00, 16'h0, 16'h0, 16'h0, 4'h0, 0, 99, e, 1'b1);
    repeat (400) @(negedge clk_i);
    check("R2 single done per run", 32'(exp_q.size()), 32'd0);
    check("R2 total dones", 32'(n_done), 32'd8);

    summary();
    $finish;
  end
endmodule